// File: doc/BRIEF.md
# Stereo Sample Gain and Soft Mute Stage

This block sits in a stereo playback path ahead of interpolation and scales each incoming pair of signed PCM samples by an 8-bit linear gain code per channel. The gain is code/256, which puts code 01h near -48.16 dB and FEh near -0.07 dB. Code 00h silences the channel, and code FFh is treated as exact unity. Each result is registered and appears one clock after the sample strobe.

A register file drives the control inputs. A code write for either channel always lands in a staging register. The staged pair moves into the applied pair, for both channels at once, only when a write carries its load bit. A shared-gain mode lets the left code drive both channels. A soft mute walks the effective gain down by one code step per sample, and releasing it walks the gain back up at the same rate, so neither direction makes a click. An output-disable level forces both outputs to midscale (code 0) and leaves every stored setting untouched.

A zero detector counts bit-clock ticks while the input has stayed all-zero. It raises a flag once the run reaches a parameterised length, 65,536 ticks by default.

Top module: `stereo_gain_stage`

## Requirements
- R1: One cycle after a clock with `in_valid` high, `out_valid` is high and each output equals (sample × applied effective code) / 256 truncated toward zero (e.g. -3 at 80h gives -1). Code FFh passes the sample unchanged and code 00h gives 0. `out_valid` is low one cycle after a clock with `in_valid` low.
- R2: After reset both applied codes and both staged codes are FFh, the soft-mute ramp stands at full scale, and `out_valid`, both outputs and `zero_flag` are 0.
- R3: A code write with its load bit at 0 only updates that channel's staged code, and samples keep the previous applied gains. A write to either channel with load bit 1 copies both staged codes, including the one written in that cycle, into the applied pair. Samples from the next clock on use the new pair.
- R4: While `cfg_common` is 1, the right channel uses the applied left code and the applied right code has no effect on the output.
- R5: While `cfg_soft_mute` is 1, each sample is scaled by the channel's effective gain g = min(applied code, ramp level). After that sample the ramp level becomes max(g-1, 0), so the gain falls one step per sample to 00h.
- R6: While `cfg_soft_mute` is 0, each sample advances the ramp level by one (saturating at FFh), so the effective gain climbs one step per sample back to the applied code.
- R7: A sample taken while `cfg_out_disable` is 1 produces 0 on both outputs. Codes and ramp state keep evolving as usual, and once the bit clears the outputs return to the programmed scaling.
- R8: With `cfg_zero_en` high, every `bit_tick` cycle during an all-zero run (the latest sample pair both zero) adds one to a count. `zero_flag` rises at the clock where the count reaches ZERO_TICKS.
- R9: A sample with any nonzero channel clears the count, and `zero_flag` is low after that same clock. With `cfg_zero_en` low the count and flag are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | SAMPLE_W | Left signed sample |
| in_right | input | SAMPLE_W | Right signed sample |
| bit_tick | input | 1 | One-cycle pulse per serial bit clock |
| cfg_left_wr | input | 1 | Write strobe for the left code |
| cfg_left_code | input | 8 | Left gain code |
| cfg_left_load | input | 1 | Load bit sent with a left write |
| cfg_right_wr | input | 1 | Write strobe for the right code |
| cfg_right_code | input | 8 | Right gain code |
| cfg_right_load | input | 1 | Load bit sent with a right write |
| cfg_common | input | 1 | Left code drives both channels |
| cfg_soft_mute | input | 1 | Soft mute request |
| cfg_out_disable | input | 1 | Force both outputs to 0 |
| cfg_zero_en | input | 1 | Zero-run detection enable |
| out_valid | output | 1 | Scaled pair valid |
| out_left | output | SAMPLE_W | Scaled left sample |
| out_right | output | SAMPLE_W | Scaled right sample |
| zero_flag | output | 1 | Long all-zero run seen |

## Verification
A scaled pair appears exactly one clock after its strobe. The bench drives each sample on a falling edge and reads the outputs shortly after the next rising edge. A code write or load changes gain starting with the first sample after the write clock, and the ramp level moves at each sample clock, so the bench model updates its codes and ramp at the same points. The zero flag is read one tick before and exactly at the clock that completes ZERO_TICKS counted ticks, and it is read again on the clock after a nonzero sample.

// File: rtl/gain_stage_pkg.sv
package gain_stage_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] gain_code_t;
  localparam gain_code_t CODE_UNITY = '1;
  localparam gain_code_t CODE_SILENT = '0;

  function automatic gain_code_t code_min(input gain_code_t a, input gain_code_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/gain_code_bank.sv
module gain_code_bank
  import gain_stage_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_l,
  input  gain_code_t code_l,
  input  logic       load_l,
  input  logic       wr_r,
  input  gain_code_t code_r,
  input  logic       load_r,
  input  logic       common,
  output gain_code_t applied_l,
  output gain_code_t applied_r,
  output gain_code_t target_l,
  output gain_code_t target_r
);
  gain_code_t stage_l, stage_r, stage_l_nx, stage_r_nx;
  logic       apply_now;

  assign stage_l_nx = wr_l ? code_l : stage_l;
  assign stage_r_nx = wr_r ? code_r : stage_r;
  assign apply_now  = (wr_l && load_l) || (wr_r && load_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_l   <= CODE_UNITY;
      stage_r   <= CODE_UNITY;
      applied_l <= CODE_UNITY;
      applied_r <= CODE_UNITY;
    end else begin
      stage_l <= stage_l_nx;
      stage_r <= stage_r_nx;
      if (apply_now) begin
        applied_l <= stage_l_nx;
        applied_r <= stage_r_nx;
      end
    end
  end

  assign target_l = applied_l;
  assign target_r = common ? applied_l : applied_r;
endmodule

// File: rtl/mute_ramp.sv
module mute_ramp
  import gain_stage_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       mute,
  input  gain_code_t target,
  output gain_code_t gain
);
  gain_code_t level, level_nx;

  assign gain = code_min(target, level);

  always_comb begin
    level_nx = level;
    if (step) begin
      if (mute) level_nx = (gain == CODE_SILENT) ? CODE_SILENT : gain - 1'b1;
      else      level_nx = (level == CODE_UNITY) ? CODE_UNITY : level + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= CODE_UNITY;
    else        level <= level_nx;
  end
endmodule

// File: rtl/gain_scaler.sv
module gain_scaler
  import gain_stage_pkg::*;
#(
  parameter int W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                force_zero,
  input  logic signed [W-1:0] sample,
  input  gain_code_t          gain,
  output logic signed [W-1:0] result
);
  function automatic logic signed [W-1:0] scaled(input logic signed [W-1:0] s,
                                                 input gain_code_t g);
    logic signed [W+CODE_W-1:0] p;
    if (g == CODE_UNITY) return s;
    p = s * $signed({1'b0, g});
    if (p < 0) p = p + (W+CODE_W)'(255);
    return W'(p >>> CODE_W);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else if (take) result <= force_zero ? '0 : scaled(sample, gain);
  end
endmodule

// File: rtl/zero_run_detect.sv
module zero_run_detect #(
  parameter int TICKS = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic take,
  input  logic pair_zero,
  input  logic tick,
  output logic flag
);
  localparam int CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TICKS);

  logic [CNT_W-1:0] count;
  logic             last_zero, zero_now;

  assign zero_now = take ? pair_zero : last_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      flag      <= 1'b0;
      last_zero <= 1'b0;
    end else begin
      last_zero <= zero_now;
      if (!enable || (take && !pair_zero)) begin
        count <= '0;
        flag  <= 1'b0;
      end else if (zero_now && tick && count != LIMIT) begin
        count <= count + 1'b1;
        flag  <= (count + 1'b1) == LIMIT;
      end
    end
  end
endmodule

// File: rtl/stereo_gain_stage.sv
module stereo_gain_stage
  import gain_stage_pkg::*;
#(
  parameter int SAMPLE_W   = 18,
  parameter int ZERO_TICKS = 65536
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  input  logic                       bit_tick,
  input  logic                       cfg_left_wr,
  input  logic [7:0]                 cfg_left_code,
  input  logic                       cfg_left_load,
  input  logic                       cfg_right_wr,
  input  logic [7:0]                 cfg_right_code,
  input  logic                       cfg_right_load,
  input  logic                       cfg_common,
  input  logic                       cfg_soft_mute,
  input  logic                       cfg_out_disable,
  input  logic                       cfg_zero_en,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic                       zero_flag
);
  localparam int NCH = 2;

  gain_code_t applied_l, applied_r, target_l, target_r;
  gain_code_t target [NCH];
  gain_code_t gain   [NCH];
  logic signed [SAMPLE_W-1:0] samp [NCH];
  logic signed [SAMPLE_W-1:0] res  [NCH];
  logic pair_zero;

  gain_code_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_l(cfg_left_wr), .code_l(cfg_left_code), .load_l(cfg_left_load),
    .wr_r(cfg_right_wr), .code_r(cfg_right_code), .load_r(cfg_right_load),
    .common(cfg_common),
    .applied_l(applied_l), .applied_r(applied_r),
    .target_l(target_l), .target_r(target_r)
  );

  assign target[0] = target_l;
  assign target[1] = target_r;
  assign samp[0]   = in_left;
  assign samp[1]   = in_right;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    mute_ramp u_ramp (
      .clk(clk), .rst_n(rst_n), .step(in_valid), .mute(cfg_soft_mute),
      .target(target[c]), .gain(gain[c])
    );
    gain_scaler #(.W(SAMPLE_W)) u_scale (
      .clk(clk), .rst_n(rst_n), .take(in_valid), .force_zero(cfg_out_disable),
      .sample(samp[c]), .gain(gain[c]), .result(res[c])
    );
  end

  assign pair_zero = (in_left == '0) && (in_right == '0);

  zero_run_detect #(.TICKS(ZERO_TICKS)) u_zero (
    .clk(clk), .rst_n(rst_n), .enable(cfg_zero_en), .take(in_valid),
    .pair_zero(pair_zero), .tick(bit_tick), .flag(zero_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  assign out_left  = res[0];
  assign out_right = res[1];
endmodule

// File: rtl/stereo_gain_stage_checks.sv
module stereo_gain_stage_checks #(
  parameter int SAMPLE_W = 18
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_left,
  input logic [SAMPLE_W-1:0] in_right,
  input logic                cfg_left_wr,
  input logic                cfg_left_load,
  input logic                cfg_right_wr,
  input logic                cfg_right_load,
  input logic                cfg_common,
  input logic                cfg_soft_mute,
  input logic                cfg_out_disable,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic                zero_flag,
  input logic [7:0]          applied_l,
  input logic [7:0]          applied_r,
  input logic [7:0]          target_r,
  input logic [7:0]          gain_l,
  input logic [7:0]          gain_r
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_left_wr && cfg_left_load) && !(cfg_right_wr && cfg_right_load)
      |=> $stable(applied_l) && $stable(applied_r));
  a_r4_common_uses_left: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_common |-> target_r == applied_l);
  a_r5_mute_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cfg_soft_mute |=> gain_l <= $past(gain_l) && gain_r <= $past(gain_r));
  a_r7_disable_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cfg_out_disable |=> out_left == '0 && out_right == '0);
  a_r9_nonzero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_left != '0 || in_right != '0) |=> !zero_flag);
endmodule

bind stereo_gain_stage stereo_gain_stage_checks #(.SAMPLE_W(SAMPLE_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_left(in_left), .in_right(in_right),
  .cfg_left_wr(cfg_left_wr), .cfg_left_load(cfg_left_load),
  .cfg_right_wr(cfg_right_wr), .cfg_right_load(cfg_right_load),
  .cfg_common(cfg_common), .cfg_soft_mute(cfg_soft_mute),
  .cfg_out_disable(cfg_out_disable), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right), .zero_flag(zero_flag),
  .applied_l(applied_l), .applied_r(applied_r), .target_r(target_r),
  .gain_l(gain[0]), .gain_r(gain[1])
);

// File: tb/test_stereo_gain_stage.sv
module test_stereo_gain_stage;
  localparam int SW = 18;
  localparam int ZT = 65536;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, bit_tick = 0;
  logic signed [SW-1:0] in_left = '0, in_right = '0;
  logic cfg_left_wr = 0, cfg_left_load = 0, cfg_right_wr = 0, cfg_right_load = 0;
  logic [7:0] cfg_left_code = '0, cfg_right_code = '0;
  logic cfg_common = 0, cfg_soft_mute = 0, cfg_out_disable = 0, cfg_zero_en = 0;
  logic out_valid, zero_flag;
  logic signed [SW-1:0] out_left, out_right;

  int total = 0, bad = 0;
  int st_l, st_r, ap_l, ap_r, lv_l, lv_r;

  always #4 clk = ~clk;

  stereo_gain_stage #(.SAMPLE_W(SW), .ZERO_TICKS(ZT)) i_stereo_gain_stage (.*);

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int ref_scale(int s, int g);
    if (g == 255) return s;
    return (s * g) / 256;
  endfunction

  function automatic int imin(int a, int b);
    return a < b ? a : b;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_code(bit right, int code, bit load);
    @(negedge clk);
    if (right) begin cfg_right_wr = 1; cfg_right_code = 8'(code); cfg_right_load = load; end
    else       begin cfg_left_wr  = 1; cfg_left_code  = 8'(code); cfg_left_load  = load; end
    if (right) st_r = code; else st_l = code;
    if (load) begin ap_l = st_l; ap_r = st_r; end
    @(negedge clk);
    cfg_left_wr = 0; cfg_right_wr = 0; cfg_left_load = 0; cfg_right_load = 0;
  endtask

  task automatic send(int l, int r, string req);
    int tl, tr, gl, gr, el, er;
    @(negedge clk);
    in_left = SW'(l); in_right = SW'(r); in_valid = 1;
    tl = ap_l; tr = cfg_common ? ap_l : ap_r;
    gl = imin(tl, lv_l); gr = imin(tr, lv_r);
    el = cfg_out_disable ? 0 : ref_scale(l, gl);
    er = cfg_out_disable ? 0 : ref_scale(r, gr);
    if (cfg_soft_mute) begin
      lv_l = gl == 0 ? 0 : gl - 1; lv_r = gr == 0 ? 0 : gr - 1;
    end else begin
      lv_l = lv_l == 255 ? 255 : lv_l + 1; lv_r = lv_r == 255 ? 255 : lv_r + 1;
    end
    @(posedge clk); #2;
    in_valid = 0;
    chk({req, " R1 valid"}, int'(out_valid), 1);
    chk({req, " left"}, int'(out_left), el);
    chk({req, " right"}, int'(out_right), er);
  endtask

  initial begin
    void'($urandom(32'd1234));
    st_l = 255; st_r = 255; ap_l = 255; ap_r = 255; lv_l = 255; lv_r = 255;
    repeat (3) @(posedge clk);
    #2;
    chk("R2 reset valid", int'(out_valid), 0);
    chk("R2 reset left", int'(out_left), 0);
    chk("R2 reset flag", int'(zero_flag), 0);
    @(negedge clk); rst_n = 1;

    send(12345, -777, "R2 unity default");
    chk("R1 idle valid", int'(out_valid), 1);
    @(posedge clk); #2;
    chk("R1 idle drops valid", int'(out_valid), 0);
    write_code(0, 8'h80, 0);
    send(1000, 1000, "R3 staged not applied");
    write_code(1, 8'h40, 1);
    send(1000, -1000, "R3 load applies both");
    send(-3, 3, "R1 truncate toward zero");
    send(-131072, 131071, "R1 extremes");
    write_code(0, 8'h00, 1);
    send(5000, 5000, "R1 code zero");
    @(negedge clk); cfg_common = 1;
    write_code(0, 8'h20, 1);
    write_code(1, 8'hF0, 1);
    send(4096, 4096, "R4 common left code");
    @(negedge clk); cfg_common = 0;
    send(4096, 4096, "R4 common released");
    @(negedge clk); cfg_out_disable = 1;
    send(9999, -9999, "R7 disabled zero");
    @(negedge clk); cfg_out_disable = 0;
    send(9999, -9999, "R7 disable cleared");
    write_code(0, 8'h05, 0);
    write_code(1, 8'h04, 1);
    @(negedge clk); cfg_soft_mute = 1;
    for (int i = 0; i < 7; i++) send(20000, -20000, "R5 mute ramp");
    chk("R5 reached silence", int'(out_left), 0);
    @(negedge clk); cfg_soft_mute = 0;
    for (int i = 0; i < 7; i++) send(20000, -20000, "R6 unmute ramp");

    for (int i = 0; i < 400; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k == 0) write_code($urandom_range(0, 1) == 1, int'($urandom_range(0, 255)),
                             $urandom_range(0, 1) == 1);
      else if (k == 1) begin @(negedge clk); cfg_soft_mute = ~cfg_soft_mute; end
      else if (k == 2) begin @(negedge clk); cfg_common = ~cfg_common; end
      else if (k == 3) begin @(negedge clk); cfg_out_disable = $urandom_range(0, 3) == 0; end
      send($signed(SW'($urandom)), $signed(SW'($urandom)), "R1 R3 R4 R5 R6 R7 random");
    end

    @(negedge clk); cfg_soft_mute = 0; cfg_out_disable = 0; cfg_zero_en = 1; bit_tick = 1;
    send(0, 0, "R8 zero sample");
    repeat (ZT - 2) @(posedge clk);
    #2 chk("R8 flag one tick early", int'(zero_flag), 0);
    @(posedge clk); #2;
    chk("R8 flag at limit", int'(zero_flag), 1);
    send(0, 7, "R9 nonzero sample");
    chk("R9 flag cleared", int'(zero_flag), 0);
    send(0, 0, "R9 restart");
    @(posedge clk); #2;
    chk("R9 short run no flag", int'(zero_flag), 0);
    @(negedge clk); cfg_zero_en = 0;
    @(posedge clk); #2;
    chk("R9 disabled flag", int'(zero_flag), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule